// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a group of already-synchronised general-purpose input lines and raises one interrupt request when any enabled line shows its programmed event. Each line is configured on its own. It can be level-sensitive, active high or active low. It can be edge-sensitive on the rising edge, the falling edge or both edges. Software sets this up through a byte-wide register bus that the block shares with the data and direction logic of the same port.

Level events are not stored: their status bit follows the input for as long as the input sits at its active level. Edge events are caught by comparing each input with its value one clock earlier. The status bit stays set until software writes a 1 to that line's bit of the clear register. Software reads the raw status and the masked status. The masked status is the raw status gated by the per-line enable. The interrupt output is a registered OR of all masked bits.

Top module: `gpio_irq_unit`

## Requirements
- R1: Four read/write byte registers sit at these offsets, with bit n belonging to line n: mode-select at 0x404, dual-edge at 0x408, polarity at 0x40C, enable at 0x410.
- R2: A mode-select bit of 1 makes its line level-sensitive. A 0 makes it edge-sensitive.
- R3: In level mode, raw status bit n equals 1 exactly while the line equals its polarity bit (1 is active high, 0 is active low). It follows the input with no register, so it drops as soon as the input leaves the active level.
- R4: In edge mode with dual-edge 0, a polarity bit of 1 detects rising edges and 0 detects falling edges. An edge is the current input differing from its value one clock earlier. Raw status shows it after the clock edge that samples the changed input.
- R5: In edge mode with dual-edge 1, either transition sets raw status and the polarity bit has no effect.
- R6: An edge event stays set until a bus write to 0x41C carries a 1 in bit n. Other bits of that write leave their lines untouched. Edge events are latched whether or not the line is enabled.
- R7: If an edge and a clear of the same line fall in the same clock, the line's status ends up set.
- R8: Raw status reads at 0x414. Masked status reads at 0x418 and equals raw status AND enable.
- R9: The interrupt output is the OR of all masked bits, registered one clock. With the enable register at 0, the output is low.
- R10: Raw and masked status ignore writes. The clear register reads as 0. Offsets outside this block read as 0.
- R11: A synchronous active-low reset clears all configuration, all latched events and the interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 8 | Synchronised input lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A table of patterns is walked, each made of a mode, dual-edge and polarity setting, a start input byte, a final input byte and an enable byte. Together the patterns separate rising from falling from dual-edge detection, active-high from active-low level sensing, and "no transition" from "transition". One pattern mixes modes across lines, so that a line-to-line crosstalk of configuration bits shows up. Directed cases then cover a partial clear, an edge colliding with its own clear, a level dropping without a clock, writes to the read-only offsets, and reset in the middle of a run.

// File: rtl/gpio_irq_pkg.sv
// Package: shared offsets and sizes of the GPIO interrupt detector.
// Assumes byte offsets on a 12-bit address; software depends on these values.
package gpio_irq_pkg;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_DUAL   = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_POL    = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h41C;
endpackage

// File: rtl/gpio_irq_cfg.sv
// Configuration registers and read mux of the interrupt detector.
// Assumes one-clock write strobes; reads are combinational on the address.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  raw_stat,
    input  logic [LINES-1:0]  masked_stat,
    output logic [LINES-1:0]  mode_lvl,
    output logic [LINES-1:0]  dual_edge,
    output logic [LINES-1:0]  polarity,
    output logic [LINES-1:0]  enable,
    output logic [LINES-1:0]  clr_pulse
);
    logic hit_mode, hit_dual, hit_pol, hit_en, hit_clr;

    // Decode which register a write targets.
    always_comb begin
        hit_mode = bus_wr && (bus_addr == OFS_MODE);
        hit_dual = bus_wr && (bus_addr == OFS_DUAL);
        hit_pol  = bus_wr && (bus_addr == OFS_POL);
        hit_en   = bus_wr && (bus_addr == OFS_ENABLE);
        hit_clr  = bus_wr && (bus_addr == OFS_CLEAR);
    end

    // Hold the four configuration bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_lvl  <= '0;
            dual_edge <= '0;
            polarity  <= '0;
            enable    <= '0;
        end else begin
            if (hit_mode) mode_lvl  <= bus_wdata;
            if (hit_dual) dual_edge <= bus_wdata;
            if (hit_pol)  polarity  <= bus_wdata;
            if (hit_en)   enable    <= bus_wdata;
        end
    end

    // Turn a write to the clear offset into one clock of clear bits.
    always_comb clr_pulse = hit_clr ? bus_wdata : '0;

    // Select read data; the clear offset and unknown offsets read 0.
    always_comb begin
        unique case (bus_addr)
            OFS_MODE:   bus_rdata = mode_lvl;
            OFS_DUAL:   bus_rdata = dual_edge;
            OFS_POL:    bus_rdata = polarity;
            OFS_ENABLE: bus_rdata = enable;
            OFS_RAW:    bus_rdata = raw_stat;
            OFS_MASKED: bus_rdata = masked_stat;
            default:    bus_rdata = '0;
        endcase
    end

    // R1: a written configuration byte is held on the next clock.
    assert_mode_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_mode |=> mode_lvl == $past(bus_wdata));
    assert_enable_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_en |=> enable == $past(bus_wdata));
endmodule

// File: rtl/gpio_irq_line.sv
// Event detector for one input line: level compare or latched edge.
// Assumes pin is already synchronised to clk.
module gpio_irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic mode_lvl,
    input  logic dual_edge,
    input  logic polarity,
    input  logic clr,
    output logic raw
);
    logic pin_prev;
    logic rise, fall, edge_hit;
    logic edge_seen;

    // Remember the input from one clock earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= 1'b0;
        else        pin_prev <= pin;
    end

    // Classify the transition against the programmed edge choice.
    always_comb begin
        rise = pin & ~pin_prev;
        fall = ~pin & pin_prev;
        if (mode_lvl)       edge_hit = 1'b0;
        else if (dual_edge) edge_hit = rise | fall;
        else if (polarity)  edge_hit = rise;
        else                edge_hit = fall;
    end

    // Sticky edge event; a new edge beats a clear in the same clock.
    always_ff @(posedge clk) begin
        if (!rst_n)        edge_seen <= 1'b0;
        else if (edge_hit) edge_seen <= 1'b1;
        else if (clr)      edge_seen <= 1'b0;
    end

    // Level lines report live; edge lines report the latch.
    always_comb raw = mode_lvl ? (pin == polarity) : edge_seen;

    // R7: an edge always leaves the latch set, clear or not.
    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> edge_seen);
    // R6: without a clear the event holds.
    assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !clr) |=> edge_seen);
    // R6: a clear with no edge drops the event.
    assert_edge_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !edge_hit) |=> !edge_seen);
    // R4: no event appears without a detected edge.
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_seen && !edge_hit) |=> !edge_seen);
endmodule

// File: rtl/gpio_irq_combine.sv
// Masks raw status with the enables and registers the OR as the interrupt.
// Assumes raw status and enables are stable in the same clock domain.
module gpio_irq_combine #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_stat,
    input  logic [LINES-1:0] enable,
    output logic [LINES-1:0] masked_stat,
    output logic             irq_out
);
    // Gate each raw bit by its enable.
    always_comb masked_stat = raw_stat & enable;

    // Register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |masked_stat;
    end

    // R9: with every enable at 0 the request is low one clock later.
    assert_enable_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |=> !irq_out);
    // R8: no masked bit without its enable.
    assert_mask_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_stat & ~enable) == '0);
endmodule

// File: rtl/gpio_irq_unit.sv
// Top of the per-line GPIO interrupt detector: registers, one detector
// per line, and the combined request. Assumes synchronised inputs.
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic              irq_out
);
    logic [LINES-1:0] mode_lvl, dual_edge, polarity, enable, clr_pulse;
    logic [LINES-1:0] raw_stat, masked_stat;

    gpio_irq_cfg #(.LINES(LINES)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .raw_stat(raw_stat), .masked_stat(masked_stat),
        .mode_lvl(mode_lvl), .dual_edge(dual_edge),
        .polarity(polarity), .enable(enable), .clr_pulse(clr_pulse)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        gpio_irq_line u_line (
            .clk(clk), .rst_n(rst_n), .pin(pin_in[i]),
            .mode_lvl(mode_lvl[i]), .dual_edge(dual_edge[i]),
            .polarity(polarity[i]), .clr(clr_pulse[i]),
            .raw(raw_stat[i])
        );
    end

    gpio_irq_combine #(.LINES(LINES)) u_comb (
        .clk(clk), .rst_n(rst_n),
        .raw_stat(raw_stat), .enable(enable),
        .masked_stat(masked_stat), .irq_out(irq_out)
    );

    // R11: the request is low in the clock after reset.
    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> !irq_out);
endmodule

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic        irq_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .irq_out(irq_out)
    );

    // mode, dual, pol, start, final, enable
    localparam logic [47:0] VEC [8] = '{
        {8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF},
        {8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h0F},
        {8'h00, 8'hFF, 8'h00, 8'hA5, 8'h5A, 8'hF0},
        {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h3C, 8'hFF},
        {8'hFF, 8'h00, 8'h00, 8'h0F, 8'h0F, 8'h33},
        {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF},
        {8'h0F, 8'hF0, 8'h55, 8'h96, 8'h69, 8'hAA},
        {8'hF0, 8'h0F, 8'hA5, 8'hFF, 8'h00, 8'h00}
    };

    function automatic logic [7:0] model(input logic [7:0] m, d, p, a, b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (m[i])      r[i] = (b[i] == p[i]);
            else if (d[i]) r[i] = (a[i] != b[i]);
            else if (p[i]) r[i] = !a[i] && b[i];
            else           r[i] = a[i] && !b[i];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic configure(input logic [7:0] m, d, p, e);
        wr(12'h404, m); wr(12'h408, d); wr(12'h40C, p); wr(12'h410, e);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11/R1: every register reads 0 after reset
        for (int a = 12'h404; a <= 12'h41C; a += 4) begin
            rd(a[11:0], v); check("R11 reset register", v, 8'h00);
        end
        check("R11 reset irq", {7'b0, irq_out}, 8'h00);
        wr(12'h404, 8'h5A); rd(12'h404, v); check("R1 mode readback", v, 8'h5A);
        wr(12'h40C, 8'hC3); rd(12'h40C, v); check("R1 polarity readback", v, 8'hC3);

        // Table walk: R2 R3 R4 R5 R8 R9
        for (int k = 0; k < 8; k++) begin
            logic [7:0] m, d, p, a, b, e, exp;
            {m, d, p, a, b, e} = VEC[k];
            exp = model(m, d, p, a, b);
            @(negedge clk); pin_in = a;
            configure(m, d, p, e);
            wr(12'h41C, 8'hFF);
            pin_in = b;
            @(negedge clk);
            rd(12'h414, v); check("R2/R3/R4/R5 raw status", v, exp);
            rd(12'h418, v); check("R8 masked status", v, exp & e);
            @(negedge clk);
            check("R9 irq", {7'b0, irq_out}, {7'b0, |(exp & e)});
        end

        // R6: partial clear, latched while disabled
        @(negedge clk); pin_in = 8'h00;
        configure(8'h00, 8'h00, 8'hFF, 8'h00);
        wr(12'h41C, 8'hFF);
        pin_in = 8'hFF;
        @(negedge clk);
        rd(12'h414, v); check("R6 latched while disabled", v, 8'hFF);
        pin_in = 8'h00;
        wr(12'h41C, 8'h0F);
        rd(12'h414, v); check("R6 selective clear", v, 8'hF0);
        check("R9 enable 0 blocks irq", {7'b0, irq_out}, 8'h00);
        repeat (3) @(negedge clk);
        rd(12'h414, v); check("R6 sticky without clear", v, 8'hF0);

        // R7: edge and clear in the same clock
        wr(12'h41C, 8'hFF);
        @(negedge clk);
        pin_in = 8'h01; bus_wr = 1'b1; bus_addr = 12'h41C; bus_wdata = 8'h01;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(12'h414, v); check("R7 edge beats clear", v, 8'h01);

        // R3: level drops without a clock edge
        configure(8'hFF, 8'h00, 8'hFF, 8'h00);
        pin_in = 8'hFF;
        rd(12'h414, v); check("R3 level active", v, 8'hFF);
        pin_in = 8'h00;
        rd(12'h414, v); check("R3 level drops live", v, 8'h00);

        // R10: read-only and write-only offsets
        pin_in = 8'hFF;
        wr(12'h410, 8'h0F);
        wr(12'h414, 8'h00); wr(12'h418, 8'h00);
        rd(12'h414, v); check("R10 raw ignores write", v, 8'hFF);
        rd(12'h418, v); check("R10 masked ignores write", v, 8'h0F);
        rd(12'h41C, v); check("R10 clear reads 0", v, 8'h00);
        rd(12'h400, v); check("R10 foreign offset reads 0", v, 8'h00);
        check("R9 irq set", {7'b0, irq_out}, 8'h01);

        // R11: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; pin_in = 8'h00;
        rd(12'h410, v); check("R11 enable cleared", v, 8'h00);
        rd(12'h404, v); check("R11 mode cleared", v, 8'h00);
        rd(12'h414, v); check("R11 status cleared", v, 8'h00);
        check("R11 irq cleared", {7'b0, irq_out}, 8'h00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule